// File: doc/BRIEF.md
# Control-Line Interrupt Flag Unit

This unit gathers interrupt events from four external handshake control lines, two belonging to port A and two to port B, together with an internal shift-register completion request. Each control line is brought into the clock domain through a synchronizer and then compared with its previous sampled level. A flag is set only when the line actually changes level in the direction chosen for it in the control register. The flags are held in a flag register. Each flag can be enabled on its own, and a single registered interrupt output is raised while any enabled flag is set.

Software reaches the unit over a simple single-cycle register bus. The bus has five registers: port B data, port A data, the line control register, the flag register and the enable register. Reading or writing either port data register is treated as servicing that port, so it clears the flags of that port's lines. The one exception is the second line of a port: if it is configured as "independent", its flag survives the access and must be cleared through the flag register.

Top module: `ctl_irq_flags`

## Requirements
- R1: After a synchronous reset the flag, enable, control and port data registers all read 0, and `irq_o` is low.
- R2: Register map on `bus_addr`: 0 = port B data, 1 = port A data, 2 = control, 3 = flags, 4 = enable. A write happens on a clock edge with `bus_sel` and `bus_wr` high. A read has `bus_sel` high and `bus_wr` low, and `bus_rdata` holds the value after the following clock edge. The port data registers read back the value last written.
- R3: Flag bit positions: A2 line = bit 0, A1 line = bit 1, shift request = bit 2, B2 line = bit 3, B1 line = bit 4. Bits 6:5 always read 0, and bit 7 reads 1 exactly when some flag is set together with its enable bit.
- R4: Control bit 0 picks the edge that sets the A1 flag, and control bit 4 does the same for the B1 flag: 1 selects a rising edge, 0 a falling edge.
- R5: Control bits 3:1 govern the A2 line and bits 7:5 the B2 line. The middle bit of each field (bit 2 and bit 6) selects a rising edge when 1 and a falling edge when 0. The lowest bit of each field (bit 1 and bit 5) selects independent mode.
- R6: A line that keeps its level, or that makes a transition of the other polarity, leaves its flag unchanged.
- R7: `sr_req_i` sets flag bit 2 in every cycle in which it is high, with no edge detection.
- R8: Any read or write of port A data clears the A1 flag. It also clears the A2 flag, unless A2 is in independent mode.
- R9: Any read or write of port B data clears the B1 flag. It also clears the B2 flag, unless B2 is in independent mode.
- R10: A write to the flag register clears every flag whose data bit is 1 and leaves the other flags as they are.
- R11: A write to the enable register with data bit 7 = 1 sets the enable bits written as 1. With bit 7 = 0 it clears them. A read of the enable register returns the enable bits in 6:0, with bit 7 reading 0.
- R12: `irq_o` is high exactly when some flag is set together with its enable bit. It follows every change of the flag or enable register, including clears caused by a port access.
- R13: A line level change applied before clock edge k shows in the flag register after edge k+2. When a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pa_ctl1_i | input | 1 | Port A first control line (asynchronous) |
| pa_ctl2_i | input | 1 | Port A second control line (asynchronous) |
| pb_ctl1_i | input | 1 | Port B first control line (asynchronous) |
| pb_ctl2_i | input | 1 | Port B second control line (asynchronous) |
| sr_req_i | input | 1 | Shift-register completion request (level) |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
Each of the four control lines is driven through rising, falling and unchanged transitions. Each is tried under both settings of its polarity bit, which shows whether the flag follows the selected edge only. Port reads and writes are then made with the second lines both in and out of independent mode, which shows whether clearing depends on the mode. The shift request is held high while its flag is being cleared, which tests the set-over-clear priority. Enable writes with bit 7 high and low separate setting from clearing, and show up in `irq_o` and in flag bit 7.

// File: rtl/ctl_irq_pkg.sv
package ctl_irq_pkg;
  localparam int FLAG_W   = 7;
  localparam int F_A2     = 0;
  localparam int F_A1     = 1;
  localparam int F_SR     = 2;
  localparam int F_B2     = 3;
  localparam int F_B1     = 4;
  localparam logic [FLAG_W-1:0] LIVE_MASK = 7'b0011111;

  localparam int NLINES   = 4;
  // line index -> flag bit
  localparam int LINE_FLAG [NLINES] = '{F_A2, F_A1, F_B2, F_B1};

  // control register bit positions
  localparam int C_A1_RISE  = 0;
  localparam int C_A2_INDEP = 1;
  localparam int C_A2_RISE  = 2;
  localparam int C_B1_RISE  = 4;
  localparam int C_B2_INDEP = 5;
  localparam int C_B2_RISE  = 6;

  typedef enum logic [2:0] {
    REG_PB   = 3'd0,
    REG_PA   = 3'd1,
    REG_CTL  = 3'd2,
    REG_FLAG = 3'd3,
    REG_EN   = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/ctl_edge_det.sv
module ctl_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic rise_sel_i,
  output logic hit_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [SYNC_STAGES:0]   fill_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= line_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      fill_q <= '0;
    end else begin
      prev_q <= sync_q[LAST];
      fill_q <= {fill_q[SYNC_STAGES-1:0], 1'b1};
    end
  end

  // armed only once the chain holds real samples, so a line idling high
  // after reset does not look like a rising edge
  assign hit_o = fill_q[SYNC_STAGES] && (sync_q[LAST] != prev_q) &&
                 (sync_q[LAST] == rise_sel_i);
endmodule

// File: rtl/ctl_flag_bank.sv
module ctl_flag_bank
  import ctl_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] set_i,
  input  logic [FLAG_W-1:0] clr_i,
  input  logic              en_wr_i,
  input  logic [7:0]        en_wdata_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic [FLAG_W-1:0] en_o,
  output logic              irq_o
);
  logic [FLAG_W-1:0] flags_q, flags_d;
  logic [FLAG_W-1:0] en_q, en_d;
  logic              irq_q;

  always_comb begin
    flags_d = ((flags_q & ~clr_i) | set_i) & LIVE_MASK;
    en_d    = en_q;
    if (en_wr_i) begin
      if (en_wdata_i[7]) en_d = en_q | en_wdata_i[FLAG_W-1:0];
      else               en_d = en_q & ~en_wdata_i[FLAG_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      en_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      en_q    <= en_d;
      irq_q   <= |(flags_d & en_d);
    end
  end

  assign flags_o = flags_q;
  assign en_o    = en_q;
  assign irq_o   = irq_q;

  assert_irq_matches_R12: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(flags_q & en_q)) else $error("irq out of step with flags");

  assert_timer_bits_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (flags_q & ~LIVE_MASK) == '0) else $error("dead flag bit set");

  for (genvar i = 0; i < FLAG_W; i++) begin : g_chk
    assert_flag_rise_needs_set_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(flags_q[i]) |-> $past(set_i[i])) else $error("flag rose without event");
    assert_flag_fall_needs_clr_R10: assert property (@(posedge clk) disable iff (rst)
      $fell(flags_q[i]) |-> ($past(clr_i[i]) && !$past(set_i[i])))
      else $error("flag fell without clear");
  end
endmodule

// File: rtl/ctl_irq_flags.sv
module ctl_irq_flags
  import ctl_irq_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              pa_ctl1_i,
  input  logic              pa_ctl2_i,
  input  logic              pb_ctl1_i,
  input  logic              pb_ctl2_i,
  input  logic              sr_req_i,
  output logic              irq_o
);
  logic [7:0]        ctl_q, pa_q, pb_q, rdata_q;
  logic [NLINES-1:0] lines, rise_sel, hit;
  logic [FLAG_W-1:0] set_vec, clr_vec, flags, en;
  logic              acc_a, acc_b, wr_flag, wr_en, any_irq;

  function automatic logic hit_reg(input logic [ADDR_W-1:0] a, input reg_sel_e r);
    return a == ADDR_W'(r);
  endfunction

  assign lines    = {pb_ctl1_i, pb_ctl2_i, pa_ctl1_i, pa_ctl2_i};
  assign rise_sel = {ctl_q[C_B1_RISE], ctl_q[C_B2_RISE],
                     ctl_q[C_A1_RISE], ctl_q[C_A2_RISE]};

  generate
    for (genvar i = 0; i < NLINES; i++) begin : g_line
      ctl_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk       (clk),
        .rst       (rst),
        .line_i    (lines[i]),
        .rise_sel_i(rise_sel[i]),
        .hit_o     (hit[i])
      );
    end
  endgenerate

  assign acc_a   = bus_sel && hit_reg(bus_addr, REG_PA);
  assign acc_b   = bus_sel && hit_reg(bus_addr, REG_PB);
  assign wr_flag = bus_sel && bus_wr && hit_reg(bus_addr, REG_FLAG);
  assign wr_en   = bus_sel && bus_wr && hit_reg(bus_addr, REG_EN);

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < NLINES; i++) set_vec[LINE_FLAG[i]] = hit[i];
    set_vec[F_SR] = sr_req_i;

    clr_vec = wr_flag ? bus_wdata[FLAG_W-1:0] : '0;
    if (acc_a) begin
      clr_vec[F_A1] = 1'b1;
      if (!ctl_q[C_A2_INDEP]) clr_vec[F_A2] = 1'b1;
    end
    if (acc_b) begin
      clr_vec[F_B1] = 1'b1;
      if (!ctl_q[C_B2_INDEP]) clr_vec[F_B2] = 1'b1;
    end
  end

  ctl_flag_bank u_bank (
    .clk       (clk),
    .rst       (rst),
    .set_i     (set_vec),
    .clr_i     (clr_vec),
    .en_wr_i   (wr_en),
    .en_wdata_i(bus_wdata),
    .flags_o   (flags),
    .en_o      (en),
    .irq_o     (irq_o)
  );

  assign any_irq = |(flags & en);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      pa_q    <= '0;
      pb_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (bus_sel && bus_wr) begin
        if (hit_reg(bus_addr, REG_CTL)) ctl_q <= bus_wdata;
        if (hit_reg(bus_addr, REG_PA))  pa_q  <= bus_wdata;
        if (hit_reg(bus_addr, REG_PB))  pb_q  <= bus_wdata;
      end
      if (bus_sel && !bus_wr) begin
        if      (hit_reg(bus_addr, REG_PB))   rdata_q <= pb_q;
        else if (hit_reg(bus_addr, REG_PA))   rdata_q <= pa_q;
        else if (hit_reg(bus_addr, REG_CTL))  rdata_q <= ctl_q;
        else if (hit_reg(bus_addr, REG_FLAG)) rdata_q <= {any_irq, flags};
        else if (hit_reg(bus_addr, REG_EN))   rdata_q <= {1'b0, en};
        else                                  rdata_q <= '0;
      end
    end
  end

  assign bus_rdata = rdata_q;

  assert_porta_clears_a1_R8: assert property (@(posedge clk) disable iff (rst)
    (acc_a && !set_vec[F_A1]) |=> !flags[F_A1]) else $error("A1 not cleared");
  assert_porta_keeps_indep_a2_R8: assert property (@(posedge clk) disable iff (rst)
    (acc_a && ctl_q[C_A2_INDEP] && flags[F_A2] && !wr_flag) |=> flags[F_A2])
    else $error("independent A2 flag lost");
  assert_portb_clears_b1_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_b && !set_vec[F_B1]) |=> !flags[F_B1]) else $error("B1 not cleared");
  assert_portb_keeps_indep_b2_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_b && ctl_q[C_B2_INDEP] && flags[F_B2] && !wr_flag) |=> flags[F_B2])
    else $error("independent B2 flag lost");
  assert_sr_sets_flag_R7: assert property (@(posedge clk) disable iff (rst)
    sr_req_i |=> flags[F_SR]) else $error("shift request lost");
endmodule

// File: tb/test_ctl_irq_flags.sv
module test_ctl_irq_flags;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       pa_c1 = 1'b0, pa_c2 = 1'b0, pb_c1 = 1'b0, pb_c2 = 1'b0;
  logic       sr_req = 1'b0;
  logic       irq;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  ctl_irq_flags i_ctl_irq_flags (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_ctl1_i(pa_c1), .pa_ctl2_i(pa_c2), .pb_ctl1_i(pb_c1), .pb_ctl2_i(pb_c2),
    .sr_req_i(sr_req), .irq_o(irq)
  );

  // {ctl[7:0], line[1:0], from, to, expect}; line 0=A2 1=A1 2=B2 3=B1
  localparam logic [12:0] VEC [12] = '{
    {8'h00, 2'd1, 1'b1, 1'b0, 1'b1},
    {8'h00, 2'd1, 1'b0, 1'b1, 1'b0},
    {8'h01, 2'd1, 1'b0, 1'b1, 1'b1},
    {8'h01, 2'd1, 1'b1, 1'b0, 1'b0},
    {8'h00, 2'd3, 1'b1, 1'b0, 1'b1},
    {8'h10, 2'd3, 1'b0, 1'b1, 1'b1},
    {8'h04, 2'd0, 1'b0, 1'b1, 1'b1},
    {8'h00, 2'd0, 1'b0, 1'b1, 1'b0},
    {8'h00, 2'd0, 1'b1, 1'b0, 1'b1},
    {8'h40, 2'd2, 1'b0, 1'b1, 1'b1},
    {8'h40, 2'd2, 1'b1, 1'b0, 1'b0},
    {8'h00, 2'd1, 1'b1, 1'b1, 1'b0}
  };
  localparam int LINE_BIT [4] = '{0, 1, 3, 4};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic set_line(input int idx, input logic v);
    @(negedge clk);
    case (idx)
      0: pa_c2 = v;
      1: pa_c1 = v;
      2: pb_c2 = v;
      default: pb_c1 = v;
    endcase
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();

    // R1: reset state
    bus_read(4'd2, r); check("R1 ctl", r, 8'h00);
    bus_read(4'd3, r); check("R1 flags", r, 8'h00);
    bus_read(4'd4, r); check("R1 enable", r, 8'h00);
    bus_read(4'd1, r); check("R1 port A", r, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    // R2: port data readback
    bus_write(4'd1, 8'h5A); bus_read(4'd1, r); check("R2 port A", r, 8'h5A);
    bus_write(4'd0, 8'hC3); bus_read(4'd0, r); check("R2 port B", r, 8'hC3);

    // R4 R5 R6: edge polarity table
    foreach (VEC[k]) begin
      bus_write(4'd2, VEC[k][12:5]);
      set_line(int'(VEC[k][4:3]), VEC[k][2]);
      settle();
      bus_write(4'd3, 8'h7F);
      set_line(int'(VEC[k][4:3]), VEC[k][1]);
      settle();
      bus_read(4'd3, r);
      check($sformatf("R4/R5/R6 vec%0d", k), {7'd0, r[LINE_BIT[VEC[k][4:3]]]},
            {7'd0, VEC[k][0]});
    end

    // R13: latency of a line edge, ctl=0 (falling) on A1
    bus_write(4'd2, 8'h00);
    set_line(1, 1'b1); settle(); bus_write(4'd3, 8'h7F);
    bus_write(4'd4, 8'h82);           // enable A1
    @(negedge clk); pa_c1 = 1'b0;     // change before edge k
    @(negedge clk); check("R13 edge k", {7'd0, irq}, 8'h00);
    @(negedge clk); check("R13 edge k+1", {7'd0, irq}, 8'h00);
    @(negedge clk); check("R13 edge k+2", {7'd0, irq}, 8'h01);
    bus_write(4'd4, 8'h02);

    // R8: port A access, A2 not independent, both falling
    pa_c1 = 1'b1; pa_c2 = 1'b1; settle(); bus_write(4'd3, 8'h7F);
    set_line(1, 1'b0); set_line(0, 1'b0); settle();
    bus_read(4'd3, r); check("R8 both set", r & 8'h1F, 8'h03);
    bus_read(4'd1, r);
    bus_read(4'd3, r); check("R8 read clears A1 A2", r & 8'h1F, 8'h00);

    // R8: A2 independent, write port A
    bus_write(4'd2, 8'h02);
    pa_c1 = 1'b1; pa_c2 = 1'b1; settle(); bus_write(4'd3, 8'h7F);
    set_line(1, 1'b0); set_line(0, 1'b0); settle();
    bus_write(4'd1, 8'h11);
    bus_read(4'd3, r); check("R8 independent A2 kept", r & 8'h1F, 8'h01);

    // R9: B2 independent, read port B; then non-independent write
    bus_write(4'd2, 8'h20);
    pb_c1 = 1'b1; pb_c2 = 1'b1; settle(); bus_write(4'd3, 8'h7F);
    set_line(3, 1'b0); set_line(2, 1'b0); settle();
    bus_read(4'd0, r);
    bus_read(4'd3, r); check("R9 independent B2 kept", r & 8'h1F, 8'h08);
    bus_write(4'd2, 8'h00);
    pb_c1 = 1'b1; pb_c2 = 1'b1; settle(); bus_write(4'd3, 8'h7F);
    set_line(3, 1'b0); set_line(2, 1'b0); settle();
    bus_write(4'd0, 8'h22);
    bus_read(4'd3, r); check("R9 write clears B1 B2", r & 8'h1F, 8'h00);

    // R10: selective clear through flag register
    bus_write(4'd2, 8'h00);
    pa_c1 = 1'b1; pb_c1 = 1'b1; settle(); bus_write(4'd3, 8'h7F);
    set_line(1, 1'b0); set_line(3, 1'b0); settle();
    bus_write(4'd3, 8'h02);
    bus_read(4'd3, r); check("R10 partial clear", r & 8'h1F, 8'h10);
    bus_write(4'd3, 8'h7F);

    // R7: single-cycle shift request
    @(negedge clk); sr_req = 1'b1; @(negedge clk); sr_req = 1'b0;
    bus_read(4'd3, r); check("R7 sr flag", r, 8'h04);

    // R11 R12 R3: enables, bit 7, irq
    check("R12 irq masked", {7'd0, irq}, 8'h00);
    bus_write(4'd4, 8'h84);
    bus_read(4'd4, r); check("R11 enable set", r, 8'h04);
    bus_read(4'd3, r); check("R3 bit7 summary", r, 8'h84);
    check("R12 irq high", {7'd0, irq}, 8'h01);
    bus_write(4'd4, 8'h04);
    bus_read(4'd4, r); check("R11 enable clear", r, 8'h00);
    check("R12 irq low after disable", {7'd0, irq}, 8'h00);

    // R13: set beats clear in the same cycle
    @(negedge clk); sr_req = 1'b1;
    bus_write(4'd3, 8'h04);
    bus_read(4'd3, r); check("R13 set wins", r & 8'h1F, 8'h04);
    @(negedge clk); sr_req = 1'b0;
    bus_write(4'd3, 8'h04);
    bus_read(4'd3, r); check("R13 clear after", r, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule